// File: doc/BRIEF.md
# CHI Data-Channel Error Encoder and Checker

This block handles the error fields that travel with data on a coherent cache's CHI DAT channel. On the receive side it takes one beat at a time. For each beat it classifies the response error code, the poison bits and the per-byte DataCheck parity. It accumulates that classification across all beats of a line. When the line ends it issues one verdict:

- whether the line may be written into data storage;
- whether the line's stored data-error flag must be set;
- whether an error report must be raised towards the bus error unit.

On the transmit side it takes the tag and data ECC results and the tag/data error flags stored with the line. From these it derives the outgoing response error code and the poison field. It also generates odd DataCheck parity over the outgoing data, which it passes through unchanged.

The receive side is driven by a three-state machine:

- `RX_IDLE` waits for a beat. A beat that is not the last moves it to `RX_COLLECT`. A last beat moves it straight to `RX_VERDICT`.
- `RX_COLLECT` ORs each further beat's flags into the line's sticky flags. It stays there until a last beat arrives, which moves it to `RX_VERDICT`.
- `RX_VERDICT` presents the verdict for exactly one cycle. It then returns to `RX_IDLE`. If a new beat arrives in that same cycle, the new line starts from clean flags: the beat goes to `RX_VERDICT` if it is last, or to `RX_COLLECT` if it is not.

The transmit side is a single registered stage.

Top module: `chi_dat_err_unit`

## Requirements
- R1: After reset `rx_done`, `rx_wr_en`, `rx_line_err`, `rx_report` and `tx_out_valid` are 0.
- R2: Response codes are encoded as OK=2'b00, EXOK=2'b01, DERR=2'b10, NDERR=2'b11. A received line whose beats carry only OK or EXOK, no poison bit and correct DataCheck gives `rx_wr_en`=1, `rx_line_err`=0 and `rx_report`=0.
- R3: Bit i of a DataCheck field covers data byte i (bits 8i+7..8i). The bit is set so that the byte and its check bit hold an odd number of ones. On transmit, `tx_out_dchk` carries this parity for `tx_out_data`.
- R4: On transmit, let T = `tx_tag_ecc_err` OR `tx_meta_tag_err` and D = `tx_data_ecc_err` OR `tx_meta_data_err`. Then:
  - T only gives NDERR with poison 0.
  - D only gives DERR with poison all 1.
  - T and D together give NDERR with poison all 1.
  - Neither gives OK with poison 0.
- R5: When `tx_wrsnp_mode` is 1, a response that would be NDERR is sent as DERR. The poison field is unchanged.
- R6: An NDERR on any beat of a received line gives `rx_wr_en`=0 in the verdict. The verdict is still issued.
- R7: NDERR or DERR on any beat, any set poison bit (bit j covers data bytes 8j..8j+7), or any DataCheck mismatch gives `rx_line_err`=1 in the verdict.
- R8: `rx_report` is 1 in the verdict only when some beat of the line failed DataCheck. Poison alone and response errors alone do not raise it.
- R9: The verdict appears for exactly one cycle, in the cycle after the beat with `rx_last` is accepted. Flags accumulate over all beats of a line, and a following line starts with clean flags.
- R10: Transmit outputs appear one cycle after `tx_valid`, with `tx_out_data` equal to the input data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received beat valid |
| rx_last | input | 1 | Received beat is the last of its line |
| rx_resp | input | 2 | Received response error code |
| rx_poison | input | 4 | Received poison bits, one per 8 bytes |
| rx_dchk | input | 32 | Received DataCheck bits, one per byte |
| rx_data | input | 256 | Received beat data |
| rx_done | output | 1 | Line verdict valid |
| rx_wr_en | output | 1 | Line may be written into storage |
| rx_line_err | output | 1 | Set the line's data-error flag |
| rx_report | output | 1 | Raise error report to the bus error unit |
| tx_valid | input | 1 | Transmit beat valid |
| tx_tag_ecc_err | input | 1 | Tag ECC check failed |
| tx_data_ecc_err | input | 1 | Data ECC check failed |
| tx_meta_tag_err | input | 1 | Stored tag-error flag of the line |
| tx_meta_data_err | input | 1 | Stored data-error flag of the line |
| tx_wrsnp_mode | input | 1 | Write/snoop transaction: NDERR not allowed |
| tx_data | input | 256 | Transmit beat data |
| tx_out_valid | output | 1 | Transmit fields valid |
| tx_out_resp | output | 2 | Outgoing response error code |
| tx_out_poison | output | 4 | Outgoing poison bits |
| tx_out_dchk | output | 32 | Outgoing DataCheck bits |
| tx_out_data | output | 256 | Outgoing data |

## Verification
The transmit side is tried with:

- all four combinations of tag and data error, each sourced once from an ECC result and once from a stored flag, which tells the priority table's rows apart;
- the same combinations with the write/snoop mode set, which isolates the NDERR clamp;
- several data patterns (zeros, ones, alternating, walking), which separate a correct per-byte odd parity from even parity or byte misordering.

The receive side is tried with single clean beats under OK and EXOK, and with single beats carrying each error source alone. These tell the write-suppress, error-flag and report outputs apart, since poison and DERR set only the flag. Two-beat lines with the error on only the first or only the last beat, followed by a back-to-back clean line, separate correct accumulation from per-beat or stale verdicts.

// File: rtl/chi_dat_err_pkg.sv
package chi_dat_err_pkg;

    typedef enum logic [1:0] {
        RESP_OK    = 2'b00,
        RESP_EXOK  = 2'b01,
        RESP_DERR  = 2'b10,
        RESP_NDERR = 2'b11
    } resp_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_COLLECT,
        RX_VERDICT
    } rx_state_e;

    typedef struct packed {
        logic nderr;
        logic derr;
        logic poisoned;
        logic dchk_fail;
    } rx_flags_t;

endpackage

// File: rtl/dat_odd_parity.sv
module dat_odd_parity #(
    parameter int BYTES = 32
) (
    input  logic [BYTES*8-1:0] data,
    output logic [BYTES-1:0]   par
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign par[b] = ~(^data[b*8 +: 8]);
    end
endmodule

// File: rtl/rx_beat_classify.sv
module rx_beat_classify
    import chi_dat_err_pkg::*;
#(
    parameter int DATA_W = 256,
    localparam int BYTES    = DATA_W / 8,
    localparam int POISON_W = DATA_W / 64
) (
    input  logic [1:0]          resp,
    input  logic [POISON_W-1:0] poison,
    input  logic [BYTES-1:0]    dchk,
    input  logic [DATA_W-1:0]   data,
    output rx_flags_t           flags
);
    logic [BYTES-1:0] want_par;

    dat_odd_parity #(.BYTES(BYTES)) par_i (
        .data (data),
        .par  (want_par)
    );

    always_comb begin
        flags           = '0;
        flags.nderr     = (resp == RESP_NDERR);
        flags.derr      = (resp == RESP_DERR);
        flags.poisoned  = |poison;
        flags.dchk_fail = |(want_par ^ dchk);
    end
endmodule

// File: rtl/tx_err_map.sv
module tx_err_map
    import chi_dat_err_pkg::*;
#(
    parameter int POISON_W = 4
) (
    input  logic                tag_err,
    input  logic                data_err,
    input  logic                wrsnp_mode,
    output logic [1:0]          resp,
    output logic [POISON_W-1:0] poison
);
    resp_e raw;

    always_comb begin
        unique case ({tag_err, data_err})
            2'b11: begin raw = RESP_NDERR; poison = '1; end
            2'b10: begin raw = RESP_NDERR; poison = '0; end
            2'b01: begin raw = RESP_DERR;  poison = '1; end
            default: begin raw = RESP_OK;  poison = '0; end
        endcase
        if (wrsnp_mode && raw == RESP_NDERR)
            resp = RESP_DERR;
        else
            resp = raw;
    end
endmodule

// File: rtl/chi_dat_err_unit.sv
module chi_dat_err_unit
    import chi_dat_err_pkg::*;
#(
    parameter int DATA_W = 256,
    localparam int BYTES    = DATA_W / 8,
    localparam int POISON_W = DATA_W / 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic                rx_last,
    input  logic [1:0]          rx_resp,
    input  logic [POISON_W-1:0] rx_poison,
    input  logic [BYTES-1:0]    rx_dchk,
    input  logic [DATA_W-1:0]   rx_data,
    output logic                rx_done,
    output logic                rx_wr_en,
    output logic                rx_line_err,
    output logic                rx_report,
    input  logic                tx_valid,
    input  logic                tx_tag_ecc_err,
    input  logic                tx_data_ecc_err,
    input  logic                tx_meta_tag_err,
    input  logic                tx_meta_data_err,
    input  logic                tx_wrsnp_mode,
    input  logic [DATA_W-1:0]   tx_data,
    output logic                tx_out_valid,
    output logic [1:0]          tx_out_resp,
    output logic [POISON_W-1:0] tx_out_poison,
    output logic [BYTES-1:0]    tx_out_dchk,
    output logic [DATA_W-1:0]   tx_out_data
);
    // ---------------- receive side ----------------
    rx_state_e state, state_nx;
    rx_flags_t beat_flags, acc_flags;

    rx_beat_classify #(.DATA_W(DATA_W)) cls_i (
        .resp   (rx_resp),
        .poison (rx_poison),
        .dchk   (rx_dchk),
        .data   (rx_data),
        .flags  (beat_flags)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE, RX_VERDICT: begin
                if (rx_valid)
                    state_nx = rx_last ? RX_VERDICT : RX_COLLECT;
                else
                    state_nx = RX_IDLE;
            end
            RX_COLLECT: begin
                if (rx_valid && rx_last)
                    state_nx = RX_VERDICT;
            end
            default: state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= RX_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_flags <= '0;
        else if (rx_valid) begin
            if (state == RX_COLLECT)
                acc_flags <= acc_flags | beat_flags;
            else
                acc_flags <= beat_flags;
        end
    end

    always_comb begin
        rx_done     = 1'b0;
        rx_wr_en    = 1'b0;
        rx_line_err = 1'b0;
        rx_report   = 1'b0;
        unique case (state)
            RX_VERDICT: begin
                rx_done     = 1'b1;
                rx_wr_en    = ~acc_flags.nderr;
                rx_line_err = |acc_flags;
                rx_report   = acc_flags.dchk_fail;
            end
            default: ;
        endcase
    end

    // ---------------- transmit side ----------------
    logic [1:0]          map_resp;
    logic [POISON_W-1:0] map_poison;
    logic [BYTES-1:0]    gen_par;

    tx_err_map #(.POISON_W(POISON_W)) map_i (
        .tag_err    (tx_tag_ecc_err | tx_meta_tag_err),
        .data_err   (tx_data_ecc_err | tx_meta_data_err),
        .wrsnp_mode (tx_wrsnp_mode),
        .resp       (map_resp),
        .poison     (map_poison)
    );

    dat_odd_parity #(.BYTES(BYTES)) tx_par_i (
        .data (tx_data),
        .par  (gen_par)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_out_valid  <= 1'b0;
            tx_out_resp   <= '0;
            tx_out_poison <= '0;
            tx_out_dchk   <= '0;
            tx_out_data   <= '0;
        end else begin
            tx_out_valid <= tx_valid;
            if (tx_valid) begin
                tx_out_resp   <= map_resp;
                tx_out_poison <= map_poison;
                tx_out_dchk   <= gen_par;
                tx_out_data   <= tx_data;
            end
        end
    end
endmodule

// File: rtl/chi_dat_err_chk.sv
module chi_dat_err_chk #(
    parameter int DATA_W = 256,
    localparam int BYTES    = DATA_W / 8,
    localparam int POISON_W = DATA_W / 64,
    localparam bit PAR_ALL  = BYTES % 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rx_valid,
    input logic                rx_last,
    input logic [1:0]          rx_resp,
    input logic [POISON_W-1:0] rx_poison,
    input logic [BYTES-1:0]    rx_dchk,
    input logic [DATA_W-1:0]   rx_data,
    input logic                rx_done,
    input logic                rx_wr_en,
    input logic                rx_line_err,
    input logic                rx_report,
    input logic                tx_valid,
    input logic                tx_tag_ecc_err,
    input logic                tx_data_ecc_err,
    input logic                tx_meta_tag_err,
    input logic                tx_meta_data_err,
    input logic                tx_wrsnp_mode,
    input logic [DATA_W-1:0]   tx_data,
    input logic                tx_out_valid,
    input logic [1:0]          tx_out_resp,
    input logic [POISON_W-1:0] tx_out_poison,
    input logic [BYTES-1:0]    tx_out_dchk,
    input logic [DATA_W-1:0]   tx_out_data
);
    // R9
    last_gives_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_last |=> rx_done);
    // R9
    verdict_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !(rx_valid && rx_last) |=> !rx_done);
    // R6
    suppress_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !rx_wr_en |-> rx_line_err);
    // R8
    report_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_report |-> rx_done && rx_line_err);
    // R5
    clamp_nderr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_wrsnp_mode |=> tx_out_resp != 2'b11);
    // R4
    no_exok_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid |-> tx_out_resp != 2'b01);
    // R4
    ok_clean_poison_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid && tx_out_resp == 2'b00 |-> tx_out_poison == '0);
    // R3
    total_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid |-> (^{tx_out_dchk, tx_out_data}) == PAR_ALL);
    // R10
    tx_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> tx_out_valid && tx_out_data == $past(tx_data));
endmodule

bind chi_dat_err_unit chi_dat_err_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/chi_dat_err_unit_tb_top.sv
`timescale 1ns/1ps
module chi_dat_err_unit_tb_top;
    localparam int DW = 256;
    localparam int NB = DW / 8;
    localparam int NP = DW / 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 0, rx_last = 0;
    logic [1:0] rx_resp = 0;
    logic [NP-1:0] rx_poison = 0;
    logic [NB-1:0] rx_dchk = 0;
    logic [DW-1:0] rx_data = 0;
    logic rx_done, rx_wr_en, rx_line_err, rx_report;
    logic tx_valid = 0, tx_tag_ecc_err = 0, tx_data_ecc_err = 0;
    logic tx_meta_tag_err = 0, tx_meta_data_err = 0, tx_wrsnp_mode = 0;
    logic [DW-1:0] tx_data = 0;
    logic tx_out_valid;
    logic [1:0] tx_out_resp;
    logic [NP-1:0] tx_out_poison;
    logic [NB-1:0] tx_out_dchk;
    logic [DW-1:0] tx_out_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    chi_dat_err_unit #(.DATA_W(DW)) dut_i (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] odd_par(logic [DW-1:0] d);
        logic [NB-1:0] p;
        for (int b = 0; b < NB; b++) begin
            int ones = 0;
            for (int k = 0; k < 8; k++) ones += d[b*8+k];
            p[b] = (ones % 2 == 0);
        end
        return p;
    endfunction

    task automatic send_beat(logic [1:0] resp, logic [NP-1:0] pois,
                             logic [DW-1:0] d, bit bad_dchk, bit last);
        rx_valid  = 1;
        rx_last   = last;
        rx_resp   = resp;
        rx_poison = pois;
        rx_data   = d;
        rx_dchk   = odd_par(d) ^ (bad_dchk ? NB'(32'h0000_0020) : '0);
        @(negedge clk);
        rx_valid = 0;
        rx_last  = 0;
    endtask

    task automatic check_verdict(string req, bit wr, bit le, bit rep);
        chk({req, " done"}, rx_done, 1);
        chk({req, " wr_en"}, rx_wr_en, wr);
        chk({req, " line_err"}, rx_line_err, le);
        chk({req, " report"}, rx_report, rep);
    endtask

    task automatic tx_send(bit t_ecc, bit d_ecc, bit t_meta, bit d_meta, bit mode,
                           logic [DW-1:0] d, logic [1:0] exp_resp, logic [NP-1:0] exp_pois,
                           string req);
        tx_valid = 1;
        tx_tag_ecc_err = t_ecc; tx_data_ecc_err = d_ecc;
        tx_meta_tag_err = t_meta; tx_meta_data_err = d_meta;
        tx_wrsnp_mode = mode; tx_data = d;
        @(negedge clk);
        tx_valid = 0;
        chk({req, " valid"}, tx_out_valid, 1);
        chk({req, " resp"}, tx_out_resp, exp_resp);
        chk({req, " poison"}, tx_out_poison, exp_pois);
        chk("R3 dchk", tx_out_dchk, odd_par(d));
        chk("R10 data", tx_out_data == d, 1);
    endtask

    task automatic t_reset;
        chk("R1 rx_done", rx_done, 0);
        chk("R1 rx_wr_en", rx_wr_en, 0);
        chk("R1 rx_line_err", rx_line_err, 0);
        chk("R1 rx_report", rx_report, 0);
        chk("R1 tx_out_valid", tx_out_valid, 0);
    endtask

    task automatic t_tx_table;
        tx_send(0,0,0,0,0, {8{32'hdead_beef}}, 2'b00, 4'h0, "R4 none");
        tx_send(1,0,0,0,0, {8{32'h1234_5678}}, 2'b11, 4'h0, "R4 tag ecc");
        tx_send(0,0,1,0,0, {8{32'h0f0f_0f0f}}, 2'b11, 4'h0, "R4 tag meta");
        tx_send(0,1,0,0,0, {8{32'haaaa_5555}}, 2'b10, 4'hf, "R4 data ecc");
        tx_send(0,0,0,1,0, '0, 2'b10, 4'hf, "R4 data meta");
        tx_send(1,0,0,1,0, '1, 2'b11, 4'hf, "R4 both");
        tx_send(0,1,1,0,0, {8{32'h8000_0001}}, 2'b11, 4'hf, "R4 both meta");
        @(negedge clk);
        chk("R10 valid drop", tx_out_valid, 0);
    endtask

    task automatic t_tx_clamp;
        tx_send(1,0,0,0,1, {8{32'h0102_0408}}, 2'b10, 4'h0, "R5 tag clamp");
        tx_send(1,1,0,0,1, {8{32'h1020_4080}}, 2'b10, 4'hf, "R5 both clamp");
        tx_send(0,1,0,0,1, {8{32'hffff_0000}}, 2'b10, 4'hf, "R5 data mode");
        tx_send(0,0,0,0,1, {8{32'h0000_0001}}, 2'b00, 4'h0, "R5 none mode");
    endtask

    task automatic t_tx_parity;
        for (int i = 0; i < 8; i++)
            tx_send(0,0,0,0,0, DW'(1) << (i * 37), 2'b00, 4'h0, "R3 walk");
    endtask

    task automatic t_rx_single;
        send_beat(2'b00, 0, {8{32'hcafe_f00d}}, 0, 1);
        check_verdict("R2 ok", 1, 0, 0);
        @(negedge clk);
        chk("R9 single cycle", rx_done, 0);
        send_beat(2'b01, 0, {8{32'h1357_9bdf}}, 0, 1);
        check_verdict("R2 exok", 1, 0, 0);
        send_beat(2'b11, 0, {8{32'h1111_2222}}, 0, 1);
        check_verdict("R6 nderr", 0, 1, 0);
        send_beat(2'b10, 0, {8{32'h3333_4444}}, 0, 1);
        check_verdict("R7 derr", 1, 1, 0);
        send_beat(2'b00, 4'b0100, {8{32'h5555_6666}}, 0, 1);
        check_verdict("R8 poison no report", 1, 1, 0);
        send_beat(2'b00, 0, {8{32'h7777_8888}}, 1, 1);
        check_verdict("R8 dchk report", 1, 1, 1);
        @(negedge clk);
    endtask

    task automatic t_rx_multi;
        send_beat(2'b00, 4'b0001, {8{32'h0bad_0bad}}, 0, 0);
        chk("R9 no early verdict", rx_done, 0);
        @(negedge clk);
        chk("R9 wait between beats", rx_done, 0);
        send_beat(2'b00, 0, {8{32'h600d_600d}}, 0, 1);
        check_verdict("R9 accumulate poison", 1, 1, 0);
        send_beat(2'b00, 0, {8{32'h2468_ace0}}, 0, 1);
        check_verdict("R9 fresh line", 1, 0, 0);
        send_beat(2'b00, 0, {8{32'h0}}, 0, 0);
        send_beat(2'b11, 0, {8{32'hffff_ffff}}, 1, 1);
        check_verdict("R6 R8 last beat", 0, 1, 1);
        @(negedge clk);
        chk("R9 back to idle", rx_done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_tx_table();
        t_tx_clamp();
        t_tx_parity();
        t_rx_single();
        t_rx_multi();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule